// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Data Unit

This block is the arithmetic core of a 16-bit fixed-point signal processor. It keeps three 16-bit operand registers and two 36-bit accumulators. On every clock edge with a valid operation it performs one operation and writes the result at that same edge. The operations are multiply, multiply-accumulate, multiply-subtract, square, add, subtract, and the bitwise AND, OR and exclusive-OR. Operands are signed Q15 fractions. A product is doubled into Q31 and sign-extended through four guard bits, so a run of accumulations can pass the ±1.0 range without losing information.

Either accumulator can feed the multiplier as a saturated 16-bit word, or feed the adder at full width. A result goes to an accumulator, or it goes in saturated 16-bit form to an operand register while both accumulators keep their values. The multiplying operations can round to the nearest 16-bit high word. A sticky flag records any wrap of the 36-bit arithmetic. A separate load port writes any register from a 16-bit data word. The host controller drives this port and the operation fields directly, one operation per cycle.

Top module: `mac_data_unit`

## Requirements
- R1: Register codes are 0 = X0, 1 = Y0, 2 = Y1, 3 = accumulator A, 4 = accumulator B. Operation codes are 0 none, 1 multiply, 2 multiply-accumulate, 3 multiply-subtract, 4 square, 5 add, 6 subtract, 7 AND, 8 OR, 9 exclusive-OR. A multiply writes the Q15×Q15 product, doubled to Q31 and sign-extended to 36 bits, into the destination at the clock edge where `op_valid` is sampled high.
- R2: Multiply-accumulate and multiply-subtract add the product to, or take it from, the accumulator picked by `acc_sel` (0 = A, 1 = B). They write the result to the destination, which may differ from the base accumulator.
- R3: Square multiplies the `src_a` operand by itself and ignores `src_b`.
- R4: Add and subtract combine the base accumulator with `src_a`. An operand register is aligned to bits 31:16 and sign-extended. An accumulator source is used at its full 36 bits.
- R5: With `round_en` set, the multiplying operations (codes 1 to 4) add 0x8000 to the 36-bit result and then clear bits 15:0. For every other operation `round_en` has no effect.
- R6: When the destination is an operand register, that register receives the saturated 16-bit form of the 36-bit result, and neither accumulator changes.
- R7: Saturation gives bits 31:16 when bits 35:31 are all equal. Otherwise it gives 0x7FFF for a positive value and 0x8000 for a negative one. It applies to `sat_a`, to `sat_b`, to an accumulator used as a multiplier operand, and to narrow destinations.
- R8: The logical operations combine bits 31:16 of the base accumulator with `src_a`. The guard bits and bits 15:0 are kept.
- R9: `ovf` is set when an arithmetic result (codes 1 to 6, rounding included) cannot be represented in 36 bits. It holds until `ovf_clr`. If a set and a clear fall in the same cycle, the set wins.
- R10: The load port writes `ld_data` into the register picked by `ld_sel`. An accumulator load places the word in bits 31:16, sign-extended, with bits 15:0 cleared. If a load and an operation target the same register in one cycle, the load wins. Operations always read the values held before the edge.
- R11: A synchronous reset clears all registers and the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 3 | Register code to load |
| ld_data | input | 16 | Load data word |
| op_valid | input | 1 | Execute the operation this cycle |
| op_code | input | 4 | Operation code |
| src_a | input | 3 | First operand register code |
| src_b | input | 3 | Second multiplier operand register code |
| acc_sel | input | 1 | Base accumulator (0 = A, 1 = B) |
| dst_sel | input | 3 | Destination register code |
| round_en | input | 1 | Round multiplying results |
| ovf_clr | input | 1 | Clear the overflow flag |
| x0_q | output | 16 | Operand register X0 |
| y0_q | output | 16 | Operand register Y0 |
| y1_q | output | 16 | Operand register Y1 |
| acc_a | output | 36 | Accumulator A |
| acc_b | output | 36 | Accumulator B |
| sat_a | output | 16 | Saturated word of A |
| sat_b | output | 16 | Saturated word of B |
| ovf | output | 1 | Sticky 36-bit overflow flag |

## Verification
The multiplier is tried with positive and negative operands, with the most negative value squared, and with a saturated accumulator as an operand. These patterns show the signed product, the Q31 doubling and whether the guard bits hold the +1.0 case. Accumulation chains that cross 1.0 separate guard-bit growth from the saturated view. Rounding is tried on halfway values with both signs, and round-half-up turns −0x8000 into zero. Doubling chains that start from the largest and the smallest value show the exact overflow boundary. They also show that a set beats a clear when both come in the same cycle.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [3:0] {
    OP_NOP = 4'd0, OP_MPY = 4'd1, OP_MAC = 4'd2, OP_MSU = 4'd3, OP_SQR = 4'd4,
    OP_ADD = 4'd5, OP_SUB = 4'd6, OP_AND = 4'd7, OP_OR  = 4'd8, OP_EOR = 4'd9
  } op_e;

  localparam int RSEL_W = 3;
  localparam int N_XREG = 3;
  localparam int N_ACC  = 2;

  function automatic logic is_mul_op(input logic [3:0] c);
    return (c == OP_MPY) || (c == OP_MAC) || (c == OP_MSU) || (c == OP_SQR);
  endfunction

  function automatic logic is_arith_op(input logic [3:0] c);
    return (c >= OP_MPY) && (c <= OP_SUB);
  endfunction

  function automatic logic is_logic_op(input logic [3:0] c);
    return (c >= OP_AND) && (c <= OP_EOR);
  endfunction
endpackage

// File: rtl/mdu_limiter.sv
module mdu_limiter #(
  parameter int DW = 16,
  parameter int GW = 4,
  localparam int AW = GW + 2 * DW
) (
  input  logic [AW-1:0] wide,
  output logic [DW-1:0] word
);
  localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NEG_MAX = {1'b1, {(DW-1){1'b0}}};

  logic [GW:0] top_bits;
  logic        fits;

  always_comb begin
    top_bits = wide[AW-1:2*DW-1];
    fits     = (&top_bits) || !(|top_bits);
    if (fits)              word = wide[2*DW-1:DW];
    else if (wide[AW-1])   word = NEG_MAX;
    else                   word = POS_MAX;
  end
endmodule

// File: rtl/mdu_product.sv
module mdu_product #(
  parameter int DW = 16,
  parameter int GW = 4,
  localparam int AW = GW + 2 * DW
) (
  input  logic [DW-1:0] mul_a,
  input  logic [DW-1:0] mul_b,
  output logic [AW-1:0] prod
);
  logic signed [2*DW-1:0] raw;

  always_comb begin
    raw  = $signed(mul_a) * $signed(mul_b);
    prod = {{(GW-1){raw[2*DW-1]}}, raw, 1'b0};
  end
endmodule

// File: rtl/mdu_adder.sv
module mdu_adder
  import mdu_pkg::*;
#(
  parameter int DW = 16,
  parameter int GW = 4,
  localparam int AW = GW + 2 * DW
) (
  input  logic [3:0]    op,
  input  logic          rnd,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] prod,
  input  logic [AW-1:0] addend,
  input  logic [DW-1:0] word,
  output logic [AW-1:0] result,
  output logic          wrap
);
  localparam int XW = AW + 2;
  localparam logic [XW-1:0] HALF = XW'(1) << (DW - 1);

  logic [XW-1:0] bx, px, sx, sum;
  logic [DW-1:0] hi_new;
  logic          do_rnd;

  always_comb begin
    bx = {{2{base[AW-1]}}, base};
    px = {{2{prod[AW-1]}}, prod};
    sx = {{2{addend[AW-1]}}, addend};
    do_rnd = rnd && is_mul_op(op);
    unique case (op)
      OP_MPY, OP_SQR: sum = px;
      OP_MAC:         sum = bx + px;
      OP_MSU:         sum = bx - px;
      OP_ADD:         sum = bx + sx;
      OP_SUB:         sum = bx - sx;
      default:        sum = bx;
    endcase
    if (do_rnd) sum = sum + HALF;

    unique case (op)
      OP_AND:  hi_new = base[2*DW-1:DW] & word;
      OP_OR:   hi_new = base[2*DW-1:DW] | word;
      OP_EOR:  hi_new = base[2*DW-1:DW] ^ word;
      default: hi_new = base[2*DW-1:DW];
    endcase

    wrap = is_arith_op(op) && !((&sum[XW-1:AW-1]) || !(|sum[XW-1:AW-1]));

    if (is_logic_op(op))
      result = {base[AW-1:2*DW], hi_new, base[DW-1:0]};
    else if (do_rnd)
      result = {sum[AW-1:DW], {DW{1'b0}}};
    else
      result = sum[AW-1:0];
  end
endmodule

// File: rtl/mdu_regfile.sv
module mdu_regfile
  import mdu_pkg::*;
#(
  parameter int DW = 16,
  parameter int GW = 4,
  localparam int AW = GW + 2 * DW
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ld_en,
  input  logic [RSEL_W-1:0]             ld_sel,
  input  logic [DW-1:0]                 ld_data,
  input  logic                          wr_en,
  input  logic [RSEL_W-1:0]             wr_sel,
  input  logic [AW-1:0]                 wr_wide,
  input  logic [DW-1:0]                 wr_narrow,
  input  logic                          ovf_set,
  input  logic                          ovf_clr,
  output logic [N_XREG-1:0][DW-1:0]     xr_q,
  output logic [N_ACC-1:0][AW-1:0]      acc_q,
  output logic                          ovf_q
);
  logic [AW-1:0] ld_wide;
  assign ld_wide = {{GW{ld_data[DW-1]}}, ld_data, {DW{1'b0}}};

  for (genvar i = 0; i < N_XREG; i++) begin : g_xreg
    always_ff @(posedge clk) begin
      if (rst)                                        xr_q[i] <= '0;
      else if (ld_en && ld_sel == RSEL_W'(i))         xr_q[i] <= ld_data;
      else if (wr_en && wr_sel == RSEL_W'(i))         xr_q[i] <= wr_narrow;
    end
  end

  for (genvar j = 0; j < N_ACC; j++) begin : g_acc
    always_ff @(posedge clk) begin
      if (rst)                                          acc_q[j] <= '0;
      else if (ld_en && ld_sel == RSEL_W'(N_XREG + j))  acc_q[j] <= ld_wide;
      else if (wr_en && wr_sel == RSEL_W'(N_XREG + j))  acc_q[j] <= wr_wide;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ovf_q <= 1'b0;
    else if (ovf_set) ovf_q <= 1'b1;
    else if (ovf_clr) ovf_q <= 1'b0;
  end
endmodule

// File: rtl/mac_data_unit.sv
module mac_data_unit
  import mdu_pkg::*;
#(
  parameter int DW = 16,
  parameter int GW = 4,
  localparam int AW = GW + 2 * DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [2:0]        ld_sel,
  input  logic [DW-1:0]     ld_data,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [2:0]        src_a,
  input  logic [2:0]        src_b,
  input  logic              acc_sel,
  input  logic [2:0]        dst_sel,
  input  logic              round_en,
  input  logic              ovf_clr,
  output logic [DW-1:0]     x0_q,
  output logic [DW-1:0]     y0_q,
  output logic [DW-1:0]     y1_q,
  output logic [AW-1:0]     acc_a,
  output logic [AW-1:0]     acc_b,
  output logic [DW-1:0]     sat_a,
  output logic [DW-1:0]     sat_b,
  output logic              ovf
);
  localparam int NLIM = N_ACC + 1;

  logic [N_XREG-1:0][DW-1:0] xr;
  logic [N_ACC-1:0][AW-1:0]  acc;
  logic [NLIM-1:0][AW-1:0]   lim_in;
  logic [NLIM-1:0][DW-1:0]   lim_out;
  logic [DW-1:0]             opa_w, opb_w, mul_b;
  logic [AW-1:0]             addend, base, prod_w, res_w;
  logic                      wrap, wr_en;

  // operand selection: operand registers raw, accumulators saturated
  always_comb begin
    opa_w  = '0;
    opb_w  = '0;
    addend = '0;
    for (int i = 0; i < N_XREG; i++) begin
      if (src_a == RSEL_W'(i)) begin
        opa_w  = xr[i];
        addend = {{GW{xr[i][DW-1]}}, xr[i], {DW{1'b0}}};
      end
      if (src_b == RSEL_W'(i)) opb_w = xr[i];
    end
    for (int j = 0; j < N_ACC; j++) begin
      if (src_a == RSEL_W'(N_XREG + j)) begin
        opa_w  = lim_out[j];
        addend = acc[j];
      end
      if (src_b == RSEL_W'(N_XREG + j)) opb_w = lim_out[j];
    end
    mul_b = (op_code == OP_SQR) ? opa_w : opb_w;
    base  = acc[acc_sel];
  end

  for (genvar k = 0; k < NLIM; k++) begin : g_lim
    if (k < N_ACC) begin : g_acc_view
      assign lim_in[k] = acc[k];
    end else begin : g_res_view
      assign lim_in[k] = res_w;
    end
    mdu_limiter #(.DW(DW), .GW(GW)) u_lim (.wide(lim_in[k]), .word(lim_out[k]));
  end

  mdu_product #(.DW(DW), .GW(GW)) u_prod (
    .mul_a(opa_w), .mul_b(mul_b), .prod(prod_w)
  );

  mdu_adder #(.DW(DW), .GW(GW)) u_add (
    .op(op_code), .rnd(round_en), .base(base), .prod(prod_w),
    .addend(addend), .word(opa_w), .result(res_w), .wrap(wrap)
  );

  assign wr_en = op_valid && (is_arith_op(op_code) || is_logic_op(op_code));

  mdu_regfile #(.DW(DW), .GW(GW)) u_rf (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .wr_en(wr_en), .wr_sel(dst_sel), .wr_wide(res_w), .wr_narrow(lim_out[N_ACC]),
    .ovf_set(op_valid && wrap), .ovf_clr(ovf_clr),
    .xr_q(xr), .acc_q(acc), .ovf_q(ovf)
  );

  assign x0_q  = xr[0];
  assign y0_q  = xr[1];
  assign y1_q  = xr[2];
  assign acc_a = acc[0];
  assign acc_b = acc[1];
  assign sat_a = lim_out[0];
  assign sat_b = lim_out[1];

  // ---------------- assertions ----------------
  localparam logic [DW-1:0] POS_LIM = {1'b0, {(DW-1){1'b1}}};

  assert_mpy_one_cycle_R1: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_MPY && dst_sel == 3'd3 && !round_en && !(ld_en && ld_sel == 3'd3))
      |=> (acc_a == $past(prod_w)));

  assert_round_clears_low_R5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && round_en && is_mul_op(op_code) && dst_sel == 3'd4 && !ld_en)
      |=> (acc_b[DW-1:0] == '0));

  assert_narrow_keeps_acc_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && dst_sel < 3'd3 && !(ld_en && ld_sel >= 3'd3))
      |=> ($stable(acc_a) && $stable(acc_b)));

  assert_sat_positive_R7: assert property (@(posedge clk) disable iff (rst)
    (!acc_a[AW-1] && (|acc_a[AW-1:2*DW-1])) |-> (sat_a == POS_LIM));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clr) |=> ovf);

  assert_load_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (ld_en && ld_sel == 3'd2) |=> (y1_q == $past(ld_data)));
endmodule

// File: tb/mac_data_unit_test.sv
`timescale 1ns/1ps
module mac_data_unit_test;
  localparam logic [2:0] RX0 = 3'd0, RY0 = 3'd1, RY1 = 3'd2, RA = 3'd3, RB = 3'd4;
  localparam logic [3:0] NOP = 4'd0, MPY = 4'd1, MAC = 4'd2, MSU = 4'd3, SQR = 4'd4,
                         ADD = 4'd5, SUB = 4'd6, ANDO = 4'd7, ORO = 4'd8, EOR = 4'd9;

  logic        clk = 1'b0;
  logic        rst, ld_en, op_valid, acc_sel, round_en, ovf_clr;
  logic [2:0]  ld_sel, src_a, src_b, dst_sel;
  logic [15:0] ld_data;
  logic [3:0]  op_code;
  logic [15:0] x0_q, y0_q, y1_q, sat_a, sat_b;
  logic [35:0] acc_a, acc_b;
  logic        ovf;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  mac_data_unit uut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .op_valid(op_valid), .op_code(op_code), .src_a(src_a), .src_b(src_b),
    .acc_sel(acc_sel), .dst_sel(dst_sel), .round_en(round_en), .ovf_clr(ovf_clr),
    .x0_q(x0_q), .y0_q(y0_q), .y1_q(y1_q), .acc_a(acc_a), .acc_b(acc_b),
    .sat_a(sat_a), .sat_b(sat_b), .ovf(ovf)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ld_en = 0; ld_sel = 0; ld_data = 0; op_valid = 0; op_code = NOP;
    src_a = 0; src_b = 0; acc_sel = 0; dst_sel = 0; round_en = 0; ovf_clr = 0;
  endtask

  task automatic load(input logic [2:0] sel, input logic [15:0] d);
    ld_en = 1; ld_sel = sel; ld_data = d;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic exec(input logic [3:0] op, input logic [2:0] sa, input logic [2:0] sb,
                      input logic as, input logic [2:0] d, input logic rnd, input logic clr);
    op_valid = 1; op_code = op; src_a = sa; src_b = sb; acc_sel = as;
    dst_sel = d; round_en = rnd; ovf_clr = clr;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic t_reset();
    chk("R11 acc_a", acc_a, 0); chk("R11 acc_b", acc_b, 0);
    chk("R11 x0", x0_q, 0); chk("R11 y1", y1_q, 0); chk("R11 ovf", ovf, 0);
  endtask

  task automatic t_multiply();
    load(RX0, 16'h4000); load(RY0, 16'h4000);
    exec(MPY, RX0, RY0, 0, RA, 0, 0);
    chk("R1 mpy +0.25", acc_a, 36'h0_2000_0000);
    load(RX0, 16'hC000);
    exec(MPY, RX0, RY0, 0, RB, 0, 0);
    chk("R1 mpy -0.25", acc_b, 36'hF_E000_0000);
  endtask

  task automatic t_accumulate();
    load(RX0, 16'h4000);
    exec(MAC, RX0, RY0, 0, RA, 0, 0);
    chk("R2 mac 1", acc_a, 36'h0_4000_0000);
    exec(MAC, RX0, RY0, 0, RA, 0, 0);
    exec(MAC, RX0, RY0, 0, RA, 0, 0);
    chk("R2 mac guard growth", acc_a, 36'h0_8000_0000);
    chk("R7 sat_a positive clamp", sat_a, 16'h7FFF);
    exec(MSU, RX0, RY0, 0, RA, 0, 0);
    chk("R2 msu", acc_a, 36'h0_6000_0000);
    chk("R7 sat_a in range", sat_a, 16'h6000);
    exec(MAC, RX0, RY0, 0, RB, 0, 0);
    chk("R2 mac base A into B", acc_b, 36'h0_8000_0000);
    chk("R2 base A untouched", acc_a, 36'h0_6000_0000);
  endtask

  task automatic t_square();
    load(RX0, 16'h8000);
    exec(SQR, RX0, RY1, 0, RB, 0, 0);
    chk("R3 square of -1", acc_b, 36'h0_8000_0000);
    load(RX0, 16'hC000);
    exec(SQR, RX0, RY0, 0, RB, 0, 0);
    chk("R3 square ignores src_b", acc_b, 36'h0_2000_0000);
  endtask

  task automatic t_round();
    load(RX0, 16'h0001); load(RY0, 16'h4000);
    exec(MPY, RX0, RY0, 0, RA, 0, 0);
    chk("R5 no round", acc_a, 36'h0_0000_8000);
    exec(MPY, RX0, RY0, 0, RA, 1, 0);
    chk("R5 round half up", acc_a, 36'h0_0001_0000);
    load(RX0, 16'hFFFF);
    exec(MPY, RX0, RY0, 0, RB, 1, 0);
    chk("R5 round negative half", acc_b, 36'h0_0000_0000);
    load(RX0, 16'h0001);
    exec(MPY, RX0, RY0, 0, RA, 0, 0);
    exec(ADD, RY0, RY0, 0, RA, 1, 0);
    chk("R5 round ignored on add", acc_a, 36'h0_4000_8000);
  endtask

  task automatic t_addsub();
    load(RB, 16'h1234); load(RX0, 16'h0100);
    exec(ADD, RX0, RX0, 1, RB, 0, 0);
    chk("R4 add aligned word", acc_b, 36'h0_1334_0000);
    load(RX0, 16'h0001);
    exec(MPY, RX0, RY0, 0, RA, 0, 0);
    exec(SUB, RA, RX0, 1, RB, 0, 0);
    chk("R4 sub full accumulator", acc_b, 36'h0_1333_8000);
    load(RX0, 16'hFFFF);
    exec(ADD, RX0, RX0, 1, RB, 0, 0);
    chk("R4 add negative word", acc_b, 36'h0_1332_8000);
  endtask

  task automatic t_narrow();
    logic [35:0] a_keep;
    load(RX0, 16'h4000); load(RY0, 16'h4000); load(RB, 16'h7FFF);
    a_keep = acc_a;
    exec(MPY, RX0, RY0, 0, RY1, 0, 0);
    chk("R6 narrow product", y1_q, 16'h2000);
    chk("R6 A kept", acc_a, a_keep);
    exec(MAC, RX0, RY0, 1, RX0, 0, 0);
    chk("R6 narrow saturates", x0_q, 16'h7FFF);
    chk("R6 B kept", acc_b, 36'h0_7FFF_0000);
  endtask

  task automatic t_acc_operand();
    load(RX0, 16'h8000); load(RY0, 16'h4000);
    exec(SQR, RX0, RX0, 0, RA, 0, 0);
    exec(MPY, RA, RY0, 0, RB, 0, 0);
    chk("R7 saturated acc as operand", acc_b, 36'h0_3FFF_8000);
    load(RB, 16'h8000);
    exec(SUB, RB, RB, 1, RB, 0, 0);
    chk("R4 sub self", acc_b, 36'h0);
  endtask

  task automatic t_logic();
    load(RX0, 16'h0001); load(RY0, 16'h4000);
    exec(MPY, RX0, RY0, 0, RA, 0, 0);
    load(RX0, 16'h0F0F);
    exec(ORO, RX0, RX0, 0, RA, 0, 0);
    chk("R8 or keeps low", acc_a, 36'h0_0F0F_8000);
    load(RX0, 16'h00FF);
    exec(ANDO, RX0, RX0, 0, RA, 0, 0);
    chk("R8 and", acc_a, 36'h0_000F_8000);
    load(RX0, 16'hFFFF);
    exec(EOR, RX0, RX0, 0, RA, 1, 0);
    chk("R8 eor keeps guard", acc_a, 36'h0_FFF0_8000);
    chk("R7 guard mismatch clamps", sat_a, 16'h7FFF);
    load(RA, 16'hF000);
    chk("R7 negative in range", sat_a, 16'hF000);
  endtask

  task automatic t_overflow();
    exec(NOP, RX0, RX0, 0, RX0, 0, 1);
    chk("R9 cleared", ovf, 0);
    load(RA, 16'h7FFF);
    for (int n = 0; n < 4; n++) exec(ADD, RA, RA, 0, RA, 0, 0);
    chk("R9 no wrap at edge", ovf, 0);
    chk("R9 largest doubled", acc_a, 36'h7_FFF0_0000);
    exec(ADD, RA, RA, 0, RA, 0, 0);
    chk("R9 wrap sets", ovf, 1);
    chk("R9 wrapped value", acc_a, 36'hF_FFE0_0000);
    exec(ANDO, RX0, RX0, 1, RB, 0, 0);
    chk("R9 sticky", ovf, 1);
    exec(NOP, RX0, RX0, 0, RX0, 0, 1);
    chk("R9 clear", ovf, 0);
    load(RA, 16'h8000);
    for (int n = 0; n < 4; n++) exec(ADD, RA, RA, 0, RA, 0, 0);
    chk("R9 most negative exact", acc_a, 36'h8_0000_0000);
    chk("R9 no wrap most negative", ovf, 0);
    exec(ADD, RA, RA, 0, RA, 0, 1);
    chk("R9 set beats clear", ovf, 1);
    exec(NOP, RX0, RX0, 0, RX0, 0, 1);
  endtask

  task automatic t_load();
    load(RY1, 16'hBEEF);
    chk("R10 load operand", y1_q, 16'hBEEF);
    load(RB, 16'h8001);
    chk("R10 load acc sign-extend", acc_b, 36'hF_8001_0000);
    load(RX0, 16'h4000); load(RY0, 16'h4000);
    ld_en = 1; ld_sel = RA; ld_data = 16'h0002;
    exec(MPY, RX0, RY0, 0, RA, 0, 0);
    chk("R10 load wins same target", acc_a, 36'h0_0002_0000);
    ld_en = 1; ld_sel = RY0; ld_data = 16'h1111;
    exec(MPY, RX0, RY0, 0, RB, 0, 0);
    chk("R10 op reads old value", acc_b, 36'h0_2000_0000);
    chk("R10 parallel load", y0_q, 16'h1111);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_multiply();
    t_accumulate();
    t_square();
    t_round();
    t_addsub();
    t_narrow();
    t_acc_operand();
    t_logic();
    t_overflow();
    t_load();
    rst = 1;
    @(negedge clk);
    rst = 0;
    t_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule